// File: doc/BRIEF.md
# Scanline Timer and Interrupt Sequencer

This block keeps the video-synchronous time base of a small 8-bit system and raises the CPU interrupt for three countdown timers. Each clock the CPU reports the cycles it just used. A free-running cycle counter absorbs them. When the counter reaches the next scanline boundary, the line number advances and a fixed number of refresh cycles are added to the counter, because the video fetcher takes them from the CPU. The line number wraps at the end of a 60 Hz or 50 Hz frame, selected by one input.

Each timer channel is armed by a load strobe that carries a delay in CPU cycles. The nearest pending event is the earliest of the next scanline boundary and the expiry of every armed channel. Expiries are only tested when the counter reaches that event. An expired channel clears its bit in an active-low status byte and disarms itself. Software returns the bit to 1 with an acknowledge strobe. The interrupt request is a level that is high while the interrupt-disable input is low and at least one status bit is 0.

Top module: `scanline_irq_seq`

## Requirements
- R1: In every clock the cycle counter advances by `step_cyc`. After reset the first scanline boundary is at counter value LINE_CYC (default 114), and each later boundary is LINE_CYC beyond the previous one. At each boundary STOLEN cycles (default 9) are added to the counter in the same clock, so with one cycle per clock the first line lasts LINE_CYC clocks and each later line lasts LINE_CYC-STOLEN clocks.
- R2: `line_num` increments at each boundary. It wraps to 0 when it increments from the frame's last line, which is LINES_NTSC-1 (default 261) when `pal_mode`=0 and LINES_PAL-1 (default 311) when `pal_mode`=1. A line number already at or beyond that last line also wraps to 0 at the next boundary.
- R3: After a synchronous active-low reset, `line_num` is 0, `irq_stat` is 0xFF, every timer is disarmed, `irq_req` is 0 and the cycle counter is 0.
- R4: A 1 on `tmr_load[k]` arms channel k with an expiry equal to the counter value before this clock's step plus `tmr_delay`. A reload replaces any pending expiry.
- R5: A channel fires in the clock in which the counter, after the step and after any refresh cycles added in that clock, reaches or passes its expiry. Firing clears status bit k, whose weight is 1, 2 or 4 for channels 0, 1 and 2. The other bits are left unchanged.
- R6: A channel that has fired stays disarmed and does not clear its bit again until it is reloaded.
- R7: A 1 on `tmr_ack[k]` sets status bit k back to 1. If channel k fires in the same clock, the clear wins. Status bits above the channels always read 1.
- R8: `irq_req` is 1 exactly when `irq_mask` is 0 and `irq_stat` is not 0xFF. It remains high until every cleared bit has been acknowledged.
- R9: If a channel is loaded in the same clock in which its old expiry would be reached, the load wins. The bit is not cleared and the new expiry applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_cyc | input | STEP_W | CPU cycles consumed in this clock |
| pal_mode | input | 1 | 1 selects the 50 Hz frame length, 0 the 60 Hz one |
| tmr_load | input | NCH | Per-channel load strobe |
| tmr_delay | input | DLY_W | Delay in CPU cycles, shared by the load strobes |
| tmr_ack | input | NCH | Per-channel acknowledge, sets the status bit |
| irq_mask | input | 1 | CPU interrupt-disable flag |
| line_num | output | LINE_W | Current scanline number |
| irq_stat | output | 8 | Interrupt status, active low per channel |
| irq_req | output | 1 | Level interrupt request to the CPU |

## Verification
The bench builds the block with LINE_CYC=20, STOLEN=4, 5 lines for the 60 Hz frame, 7 lines for the 50 Hz frame and a 16-bit counter. At these sizes both frame wraps, a switch from the long frame to the short one at a line past the short frame's end, and many boundaries with single-cycle and seven-cycle steps all occur within a few hundred clocks. The short line also makes it easy to place a timer expiry inside the refresh window, to load a channel exactly when it would expire, and to acknowledge a channel in the clock in which it fires.

// File: rtl/scanline_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the scanline timer and interrupt sequencer.
package scanline_irq_pkg;
    // Width of the interrupt status byte seen by the CPU.
    localparam int STAT_W = 8;

    // Larger of two integers, used to size the line number.
    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/scanline_line_track.sv
`timescale 1ns/1ps
// Cycle counter and scanline tracker.
// Adds the CPU step to the counter. When the event gate is open and the raw
// count has reached the next line boundary, it advances the line number (with
// frame wrap) and adds the refresh cycles taken by the video fetcher.
// Assumes step_cyc + STOLEN < LINE_CYC, so at most one boundary per clock.
module scanline_line_track #(
    parameter int CNT_W      = 32,
    parameter int STEP_W     = 4,
    parameter int LINE_CYC   = 114,
    parameter int STOLEN     = 9,
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 312,
    parameter int LINE_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_cyc,
    input  logic              pal_mode,
    input  logic              evt_hit,
    output logic [CNT_W-1:0]  cyc_q,
    output logic [CNT_W-1:0]  cyc_raw,
    output logic [CNT_W-1:0]  cyc_post,
    output logic [CNT_W-1:0]  next_line_q,
    output logic [LINE_W-1:0] line_q
);
    localparam logic [CNT_W-1:0]  CYC_LINE  = CNT_W'(LINE_CYC);
    localparam logic [CNT_W-1:0]  CYC_STEAL = CNT_W'(STOLEN);
    localparam logic [LINE_W-1:0] LAST_NTSC = LINE_W'(LINES_NTSC - 1);
    localparam logic [LINE_W-1:0] LAST_PAL  = LINE_W'(LINES_PAL - 1);
    localparam logic [LINE_W-1:0] LAST_MAX  = (LINES_PAL > LINES_NTSC) ? LAST_PAL : LAST_NTSC;

    logic              crossing;
    logic [LINE_W-1:0] last_line;
    logic [LINE_W-1:0] line_nx;

    // Raw count, boundary detection and refresh insertion.
    always_comb begin
        cyc_raw   = cyc_q + CNT_W'(step_cyc);
        crossing  = evt_hit && (cyc_raw >= next_line_q);
        cyc_post  = crossing ? (cyc_raw + CYC_STEAL) : cyc_raw;
        last_line = pal_mode ? LAST_PAL : LAST_NTSC;
        line_nx   = (line_q >= last_line) ? '0 : (line_q + 1'b1);
    end

    // Counter, next boundary and line number registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q       <= '0;
            next_line_q <= CYC_LINE;
            line_q      <= '0;
        end else begin
            cyc_q <= cyc_post;
            if (crossing) begin
                next_line_q <= next_line_q + CYC_LINE;
                line_q      <= line_nx;
            end
        end
    end

    // The line number never leaves the longer frame.
    assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST_MAX);

    // A line change always comes with exactly one boundary step.
    assert_boundary_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q != $past(line_q)) |-> (next_line_q == $past(next_line_q) + CYC_LINE));
endmodule

// File: rtl/scanline_timer_chan.sv
`timescale 1ns/1ps
// One countdown timer channel with a self-disarming, active-low status bit.
// A load arms the channel at the current count plus the delay. When the event
// gate is open and the post-refresh count reaches the expiry, the status bit
// drops and the channel disarms. An acknowledge raises the bit unless the
// channel fires in the same clock. A load takes precedence over firing.
module scanline_timer_chan #(
    parameter int CNT_W = 32,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] delay,
    input  logic             ack,
    input  logic             evt_hit,
    input  logic [CNT_W-1:0] cyc_q,
    input  logic [CNT_W-1:0] cyc_post,
    output logic             armed_q,
    output logic [CNT_W-1:0] exp_q,
    output logic             stat_q
);
    logic fire;

    // Expiry test, only while armed, gated by the event and blocked by a load.
    always_comb begin
        fire = evt_hit && armed_q && !load && (cyc_post >= exp_q);
    end

    // Arm state and expiry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            exp_q   <= '0;
        end else if (load) begin
            armed_q <= 1'b1;
            exp_q   <= cyc_q + CNT_W'(delay);
        end else if (fire) begin
            armed_q <= 1'b0;
        end
    end

    // Active-low status bit: firing clears it, acknowledge sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b1;
        end else if (fire) begin
            stat_q <= 1'b0;
        end else if (ack) begin
            stat_q <= 1'b1;
        end
    end

    // A bit that drops belongs to a channel that is no longer armed.
    assert_disarm_on_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q) |-> !armed_q);

    // A pending expiry only changes through a load.
    assert_expiry_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q) && !$past(load)) |-> (exp_q == $past(exp_q)));

    // An acknowledge without a simultaneous firing leaves the bit high.
    assert_ack_raises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack && !fire) |-> stat_q);
endmodule

// File: rtl/scanline_evt_min.sv
`timescale 1ns/1ps
// Nearest-event selector: the minimum of the next line boundary and the
// expiry of every armed channel. Purely combinational.
module scanline_evt_min #(
    parameter int CNT_W = 32,
    parameter int NCH   = 3
) (
    input  logic [CNT_W-1:0]          base,
    input  logic [NCH-1:0][CNT_W-1:0] cand,
    input  logic [NCH-1:0]            valid,
    output logic [CNT_W-1:0]          lim
);
    // Linear minimum scan over the armed candidates.
    always_comb begin
        lim = base;
        for (int k = 0; k < NCH; k++) begin
            if (valid[k] && (cand[k] < lim)) begin
                lim = cand[k];
            end
        end
    end
endmodule

// File: rtl/scanline_irq_seq.sv
`timescale 1ns/1ps
// Scanline timer and interrupt sequencer top.
// Combines the line tracker, NCH timer channels and the nearest-event
// selector. The status byte is active low per channel with the unused upper
// bits held at 1. The request is a level for the CPU.
// Assumes NCH <= 8 and a CPU step below LINE_CYC - STOLEN per clock.
module scanline_irq_seq
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int STEP_W     = 4,
    parameter int DLY_W      = 16,
    parameter int NCH        = 3,
    parameter int LINE_CYC   = 114,
    parameter int STOLEN     = 9,
    parameter int LINES_NTSC = 262,
    parameter int LINES_PAL  = 312,
    localparam int LINE_W    = $clog2(max_i(LINES_NTSC, LINES_PAL))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_cyc,
    input  logic              pal_mode,
    input  logic [NCH-1:0]    tmr_load,
    input  logic [DLY_W-1:0]  tmr_delay,
    input  logic [NCH-1:0]    tmr_ack,
    input  logic              irq_mask,
    output logic [LINE_W-1:0] line_num,
    output logic [STAT_W-1:0] irq_stat,
    output logic              irq_req
);
    logic [CNT_W-1:0]          cyc_q;
    logic [CNT_W-1:0]          cyc_raw;
    logic [CNT_W-1:0]          cyc_post;
    logic [CNT_W-1:0]          next_line_q;
    logic [CNT_W-1:0]          evt_lim;
    logic                      evt_hit;
    logic [NCH-1:0]            armed;
    logic [NCH-1:0][CNT_W-1:0] exp_all;
    logic [NCH-1:0]            stat_bits;

    scanline_line_track #(
        .CNT_W(CNT_W), .STEP_W(STEP_W), .LINE_CYC(LINE_CYC), .STOLEN(STOLEN),
        .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL), .LINE_W(LINE_W)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .step_cyc(step_cyc), .pal_mode(pal_mode),
        .evt_hit(evt_hit), .cyc_q(cyc_q), .cyc_raw(cyc_raw), .cyc_post(cyc_post),
        .next_line_q(next_line_q), .line_q(line_num)
    );

    scanline_evt_min #(.CNT_W(CNT_W), .NCH(NCH)) u_min (
        .base(next_line_q), .cand(exp_all), .valid(armed), .lim(evt_lim)
    );

    // Event gate: expiries and boundaries are examined only once reached.
    always_comb begin
        evt_hit = (cyc_raw >= evt_lim);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        scanline_timer_chan #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load(tmr_load[k]), .delay(tmr_delay),
            .ack(tmr_ack[k]), .evt_hit(evt_hit), .cyc_q(cyc_q), .cyc_post(cyc_post),
            .armed_q(armed[k]), .exp_q(exp_all[k]), .stat_q(stat_bits[k])
        );

        // The selected event never lies beyond an armed expiry.
        assert_evt_before_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
            armed[k] |-> (evt_lim <= exp_all[k]));
    end

    // Status byte assembly and the level request.
    always_comb begin
        irq_stat = '1;
        irq_stat[NCH-1:0] = stat_bits;
        irq_req = !irq_mask && (irq_stat != {STAT_W{1'b1}});
    end

    // The selected event never lies beyond the next line boundary.
    assert_evt_before_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lim <= next_line_q);

    // Without an acknowledge a pending request stays up while enabled.
    assert_request_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (tmr_ack == '0)) |=> (irq_req || irq_mask));
endmodule

// File: tb/scanline_irq_seq_test.sv
`timescale 1ns/1ps
// Directed bench for the scanline timer and interrupt sequencer.
module scanline_irq_seq_test;
    localparam int CNT_W = 16, STEP_W = 4, DLY_W = 8, NCH = 3;
    localparam int LINE_CYC = 20, STOLEN = 4, LN_NTSC = 5, LN_PAL = 7;
    localparam int LINE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [STEP_W-1:0] step_cyc = '0;
    logic pal_mode = 1'b0;
    logic [NCH-1:0] tmr_load = '0;
    logic [DLY_W-1:0] tmr_delay = '0;
    logic [NCH-1:0] tmr_ack = '0;
    logic irq_mask = 1'b0;
    logic [LINE_W-1:0] line_num;
    logic [7:0] irq_stat;
    logic irq_req;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference state derived from the requirements.
    int mcyc, mnext, mline;
    int mexp[NCH];
    bit marm[NCH];
    bit [NCH-1:0] mstat;

    scanline_irq_seq #(
        .CNT_W(CNT_W), .STEP_W(STEP_W), .DLY_W(DLY_W), .NCH(NCH),
        .LINE_CYC(LINE_CYC), .STOLEN(STOLEN), .LINES_NTSC(LN_NTSC), .LINES_PAL(LN_PAL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .step_cyc(step_cyc), .pal_mode(pal_mode),
        .tmr_load(tmr_load), .tmr_delay(tmr_delay), .tmr_ack(tmr_ack),
        .irq_mask(irq_mask), .line_num(line_num), .irq_stat(irq_stat), .irq_req(irq_req)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int m_stat();
        return int'({5'b11111, mstat});
    endfunction

    function automatic int m_irq();
        return (!irq_mask && (mstat != 3'b111)) ? 1 : 0;
    endfunction

    task automatic chk_model(input string req);
        chk({req, " line"}, int'(line_num), mline);
        chk({req, " stat"}, int'(irq_stat), m_stat());
        chk({req, " irq"}, int'(irq_req), m_irq());
    endtask

    // One clock: drive inputs, take the edge, advance the reference.
    task automatic tick(input int s, input bit [NCH-1:0] ld, input bit [NCH-1:0] ak, input int dly);
        int cn;
        bit [NCH-1:0] fired;
        step_cyc = STEP_W'(s); tmr_load = ld; tmr_ack = ak; tmr_delay = DLY_W'(dly);
        @(posedge clk); #1;
        cn = mcyc + s;
        fired = '0;
        if (cn >= mnext) begin
            mline = (mline >= (pal_mode ? LN_PAL : LN_NTSC) - 1) ? 0 : mline + 1;
            cn += STOLEN;
            mnext += LINE_CYC;
        end
        for (int k = 0; k < NCH; k++) begin
            if (ld[k]) begin
                mexp[k] = mcyc + dly; marm[k] = 1;
            end else if (marm[k] && cn >= mexp[k]) begin
                marm[k] = 0; fired[k] = 1; mstat[k] = 0;
            end
            if (ak[k] && !fired[k]) mstat[k] = 1;
        end
        mcyc = cn;
        tmr_load = '0; tmr_ack = '0;
    endtask

    task automatic align(input int g);
        while (mnext - mcyc < g) tick(1, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R3 line", int'(line_num), 0);
        chk("R3 stat", int'(irq_stat), 8'hFF);
        chk("R3 irq", int'(irq_req), 0);
    endtask

    task automatic t_line_timing();
        for (int i = 0; i < 19; i++) tick(1, 0, 0, 0);
        chk("R1 first line not over", int'(line_num), 0);
        tick(1, 0, 0, 0);
        chk("R1 first line length", int'(line_num), 1);
        for (int i = 0; i < 15; i++) tick(1, 0, 0, 0);
        chk("R1 refresh shortens line", int'(line_num), 1);
        tick(1, 0, 0, 0);
        chk("R1 second line length", int'(line_num), 2);
    endtask

    task automatic t_frame_wrap();
        int mism = 0;
        bit saw_wrap = 0;
        pal_mode = 0;
        for (int i = 0; i < 120; i++) begin
            tick(1, 0, 0, 0);
            if (int'(line_num) != mline) mism++;
            if (mline == 0 && i > 0) saw_wrap = 1;
        end
        chk("R2 60Hz frame wrap", mism, 0);
        chk("R2 wrap reached", int'(saw_wrap), 1);
        pal_mode = 1;
        while (mline != 6) tick(1, 0, 0, 0);
        chk("R2 50Hz reaches line 6", int'(line_num), 6);
        pal_mode = 0;
        while (mline == 6) tick(1, 0, 0, 0);
        chk("R2 beyond short frame wraps", int'(line_num), 0);
    endtask

    task automatic t_timer_fire();
        int mism = 0;
        align(12);
        tick(1, 3'b010, 0, 10);
        for (int i = 0; i < 20 && mstat[1]; i++) begin
            if (int'(irq_stat) != m_stat()) mism++;
            tick(1, 0, 0, 0);
        end
        chk("R4 no early firing", mism, 0);
        chk("R5 channel 1 weight 2", int'(irq_stat), 8'hFD);
        chk("R8 request raised", int'(irq_req), 1);
        irq_mask = 1; #1;
        chk("R8 masked", int'(irq_req), 0);
        irq_mask = 0; #1;
        chk("R8 unmasked", int'(irq_req), 1);
    endtask

    task automatic t_disarm();
        tick(1, 0, 3'b010, 0);
        chk("R7 acknowledge", int'(irq_stat), 8'hFF);
        for (int i = 0; i < 40; i++) tick(1, 0, 0, 0);
        chk("R6 no second firing", int'(irq_stat), 8'hFF);
        chk("R6 request idle", int'(irq_req), 0);
    endtask

    task automatic t_ack_vs_fire();
        align(12);
        tick(1, 3'b001, 0, 3);
        tick(1, 0, 0, 0);
        chk("R5 not yet", int'(irq_stat), 8'hFF);
        tick(1, 0, 3'b001, 0);
        chk("R7 fire beats ack", int'(irq_stat), 8'hFE);
        tick(1, 0, 3'b001, 0);
        chk_model("R7 cleanup");
    endtask

    task automatic t_reload();
        align(12);
        tick(1, 3'b100, 0, 4);
        tick(1, 3'b100, 0, 6);
        tick(1, 0, 0, 0); tick(1, 0, 0, 0);
        chk("R4 old expiry replaced", int'(irq_stat), 8'hFF);
        tick(1, 0, 0, 0); tick(1, 0, 0, 0);
        chk("R4 before new expiry", int'(irq_stat), 8'hFF);
        tick(1, 0, 0, 0);
        chk("R4 new expiry fires", int'(irq_stat), 8'hFB);
        tick(1, 0, 3'b100, 0);
    endtask

    task automatic t_load_at_fire();
        align(12);
        tick(1, 3'b100, 0, 2);
        tick(1, 3'b100, 0, 3);
        chk("R9 load beats fire", int'(irq_stat), 8'hFF);
        tick(1, 0, 0, 0);
        chk("R9 still pending", int'(irq_stat), 8'hFF);
        tick(1, 0, 0, 0);
        chk("R9 fires at new expiry", int'(irq_stat), 8'hFB);
        tick(1, 0, 3'b100, 0);
    endtask

    task automatic t_stolen_window();
        int l0;
        while (mnext - mcyc != 3) tick(1, 0, 0, 0);
        l0 = mline;
        tick(1, 3'b001, 0, 5);
        tick(1, 0, 0, 0);
        chk("R5 expiry inside refresh pending", int'(irq_stat), 8'hFF);
        tick(1, 0, 0, 0);
        chk("R5 fires with refresh cycles", int'(irq_stat), 8'hFE);
        chk("R5 same clock as boundary", int'(line_num), (l0 + 1) % LN_NTSC);
        tick(1, 0, 3'b001, 0);
    endtask

    task automatic t_all_channels();
        align(12);
        tick(1, 3'b111, 0, 5);
        for (int i = 0; i < 5; i++) tick(1, 0, 0, 0);
        chk("R5 all fire", int'(irq_stat), 8'hF8);
        tick(1, 0, 3'b001, 0);
        chk("R7 partial ack", int'(irq_stat), 8'hF9);
        chk("R8 still requesting", int'(irq_req), 1);
        tick(1, 0, 3'b110, 0);
        chk("R8 request drops", int'(irq_req), 0);
        chk_model("R7 model");
    endtask

    task automatic t_big_steps();
        int mism = 0;
        for (int i = 0; i < 60; i++) begin
            tick(7, 0, 0, 0);
            if (int'(line_num) != mline) mism++;
        end
        chk("R1 seven-cycle steps", mism, 0);
        chk_model("R1 final");
    endtask

    initial begin
        mcyc = 0; mnext = LINE_CYC; mline = 0; mstat = '1;
        for (int k = 0; k < NCH; k++) begin mexp[k] = 0; marm[k] = 0; end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_line_timing();
        t_frame_wrap();
        t_timer_fire();
        t_disarm();
        t_ack_vs_fire();
        t_reload();
        t_load_at_fire();
        t_stolen_window();
        t_all_channels();
        t_big_steps();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule